// File: doc/BRIEF.md
# Status Register Write Mask Unit

This unit holds a processor's current status register and its saved status register, and carries out the instructions that move a value into one of them or copy one of them out. For a write, two field-select bits in the instruction word pick the flag byte, the control byte, or both. The resulting byte mask is then cut down before anything is written. For the current register, the cut depends on privilege. For the saved register, it depends on a fixed set of writable bits. The value written comes either from a register operand or from an 8-bit immediate rotated by an amount encoded in the instruction.

When a privileged write changes the control byte of the current register, the unit raises a one-cycle strobe that carries the new 5-bit mode. The surrounding core uses it to switch banked registers. For a read, the unit returns the full 32-bit value of the selected register and passes on the destination register index from the instruction. Writes take effect on the clock edge that samples the valid strobe.

Top module: `psr_write_unit`

## Requirements
- R1: After reset the current register holds 0x000000D3 (both interrupt masks set, mode 0b10011), the saved register holds 0, and `mode_chg` is 0.
- R2: Instruction bit 19 selects the flag byte (mask 0xFF000000) and bit 16 selects the control byte (mask 0x000000FF). A write with neither bit set changes nothing, and bits 27:8 of the current register are never written.
- R3: A write to the current register with bit 19 set replaces bits 31:28 with operand bits 31:28 in every mode, user mode included.
- R4: A write to the current register with bit 16 set replaces bits 7:6 with operand bits 7:6 and bits 4:0 with {1, operand[3:0]}, but only when `cur_mode` is not user mode (0b10000). Bit 5 is never changed by such a write.
- R5: In the cycle after a privileged control write to the current register, `mode_chg` is 1 and `new_mode` equals {1, operand[3:0]}, which is also the new value of bits 4:0. In every other cycle `mode_chg` is 0.
- R6: A write to the saved register uses the selected byte mask ANDed with 0xF00000EF. Bit 5 is therefore writable, bits 27:8 and bit 4 keep their value, no privilege check is made, and `mode_chg` stays 0.
- R7: When instruction bit 25 is 1, the operand is instruction bits 7:0 rotated right by twice the value of bits 11:8. When bit 25 is 0, the operand is `reg_operand`.
- R8: While `op_valid` and `op_read` are both 1, `rd_valid` is 1, `rd_data` is the full selected register (saved if `op_saved` is 1), and `rd_dest` is instruction bits 15:12. A read modifies neither register.
- R9: With `op_valid` at 0, neither register changes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction present this cycle |
| op_read | input | 1 | 1 = copy a register out, 0 = write into one |
| op_saved | input | 1 | 1 = saved register, 0 = current register |
| instr | input | 32 | Instruction word |
| reg_operand | input | 32 | Register source operand |
| cur_mode | input | 5 | Current privilege mode |
| cpsr_q | output | 32 | Current status register |
| spsr_q | output | 32 | Saved status register |
| mode_chg | output | 1 | One-cycle strobe after a privileged mode write |
| new_mode | output | 5 | Mode carried with the strobe |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Value of the selected register |
| rd_dest | output | 4 | Destination register index for the read |

## Verification
A single write to the current register can carry a flag update and a privileged control update at once, and the control update also raises the mode strobe. The bench provokes this with field bits 16 and 19 both set in supervisor mode. It then checks the whole register word and the strobe together on the following cycle. It repeats the same dual-field write in user mode, where the flags must change while the low byte and the strobe must not. It also issues a read in the cycle right after a write, so that the value returned shows the write has already landed.

// File: rtl/psr_write_unit.sv
module psr_write_unit #(
  parameter logic [31:0] RESET_CPSR = 32'h0000_00D3,
  parameter logic [4:0]  USER_MODE  = 5'b10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic        op_read,
  input  logic        op_saved,
  input  logic [31:0] instr,
  input  logic [31:0] reg_operand,
  input  logic [4:0]  cur_mode,
  output logic [31:0] cpsr_q,
  output logic [31:0] spsr_q,
  output logic        mode_chg,
  output logic [4:0]  new_mode,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic [3:0]  rd_dest
);

  localparam logic [31:0] SAVED_WR_MASK = 32'hF000_00EF;

  logic [31:0] imm_word;
  logic [63:0] imm_pair;
  logic [4:0]  imm_rot;
  logic [31:0] opnd;
  logic [31:0] byte_mask;
  logic [31:0] saved_mask;
  logic        wr_any, wr_cur, wr_sav, ctrl_ok;

  assign imm_word   = {24'h0, instr[7:0]};
  assign imm_rot    = {instr[11:8], 1'b0};
  assign imm_pair   = {imm_word, imm_word} >> imm_rot;
  assign opnd       = instr[25] ? imm_pair[31:0] : reg_operand;

  assign byte_mask  = {{8{instr[19]}}, 16'h0000, {8{instr[16]}}};
  assign saved_mask = byte_mask & SAVED_WR_MASK;

  assign wr_any  = op_valid & ~op_read;
  assign wr_cur  = wr_any & ~op_saved;
  assign wr_sav  = wr_any & op_saved;
  assign ctrl_ok = instr[16] & (cur_mode != USER_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpsr_q   <= RESET_CPSR;
      spsr_q   <= 32'h0;
      mode_chg <= 1'b0;
      new_mode <= RESET_CPSR[4:0];
    end else begin
      mode_chg <= wr_cur & ctrl_ok;
      if (wr_cur) begin
        if (instr[19]) cpsr_q[31:28] <= opnd[31:28];
        if (ctrl_ok) begin
          cpsr_q[7:6] <= opnd[7:6];
          cpsr_q[4:0] <= {1'b1, opnd[3:0]};
          new_mode    <= {1'b1, opnd[3:0]};
        end
      end
      if (wr_sav) spsr_q <= (spsr_q & ~saved_mask) | (opnd & saved_mask);
    end
  end

  assign rd_valid = op_valid & op_read;
  assign rd_data  = op_saved ? spsr_q : cpsr_q;
  assign rd_dest  = instr[15:12];

  AST_USER_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cur && cur_mode == USER_MODE) |=> (cpsr_q[7:0] == $past(cpsr_q[7:0]) && !mode_chg)); // R4
  AST_STATE_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur |=> (cpsr_q[5] == $past(cpsr_q[5]))); // R4
  AST_STROBE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> (new_mode[4] && cpsr_q[4:0] == new_mode)); // R5
  AST_SAVED_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sav |=> (spsr_q[27:8] == $past(spsr_q[27:8]) && spsr_q[4] == $past(spsr_q[4]) && !mode_chg)); // R6
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_read) |=> ($stable(cpsr_q) && $stable(spsr_q))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(cpsr_q) && $stable(spsr_q) && !mode_chg)); // R9
  AST_FLAT_MIDDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur |=> (cpsr_q[27:8] == $past(cpsr_q[27:8]))); // R2

endmodule

// File: tb/psr_write_unit_test.sv
module psr_write_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_read = 1'b0, op_saved = 1'b0;
  logic [31:0] instr = '0, reg_operand = '0;
  logic [4:0]  cur_mode = 5'b10011;
  logic [31:0] cpsr_q, spsr_q, rd_data;
  logic        mode_chg, rd_valid;
  logic [4:0]  new_mode;
  logic [3:0]  rd_dest;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  psr_write_unit uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_read(op_read),
    .op_saved(op_saved), .instr(instr), .reg_operand(reg_operand), .cur_mode(cur_mode),
    .cpsr_q(cpsr_q), .spsr_q(spsr_q), .mode_chg(mode_chg), .new_mode(new_mode),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_dest(rd_dest));

  localparam int NV = 9;
  localparam logic [31:0] V_INSTR [NV] = '{32'h0009_0000, 32'h0009_0000, 32'h0009_0000,
    32'h0001_0000, 32'h0208_0460, 32'h0201_001F, 32'h0000_0000, 32'h0209_01C3, 32'h0009_0000};
  localparam logic [31:0] V_OPND [NV] = '{32'hA000_00D1, 32'h5FFF_FF1F, 32'hFFFF_FFFF,
    32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0FFF_FF00};
  localparam logic [4:0] V_MODE [NV] = '{5'h13, 5'h10, 5'h10, 5'h13, 5'h13, 5'h13, 5'h13, 5'h10, 5'h13};
  localparam logic V_SAV [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] E_CPSR [NV] = '{32'hA000_00D1, 32'h5000_00D1, 32'h5000_00D1,
    32'h5000_00D1, 32'h6000_00D1, 32'h6000_001F, 32'h6000_001F, 32'h6000_001F, 32'h0000_0010};
  localparam logic [31:0] E_SPSR [NV] = '{32'h0, 32'h0, 32'hF000_00EF, 32'hF000_0000,
    32'hF000_0000, 32'hF000_0000, 32'hF000_0000, 32'hC000_0020, 32'hC000_0020};
  localparam logic E_CHG [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [4:0] E_NMODE [NV] = '{5'h11, 5'h11, 5'h11, 5'h11, 5'h11, 5'h1F, 5'h1F, 5'h1F, 5'h10};
  localparam string V_TAG [NV] = '{"R3/R4/R5", "R3/R4", "R6", "R6", "R7/R3", "R7/R4/R5", "R2", "R7/R6", "R2/R4/R5"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic rd, input logic sv, input logic [4:0] md,
                       input logic [31:0] ins, input logic [31:0] opr);
    op_valid = 1'b1; op_read = rd; op_saved = sv; cur_mode = md; instr = ins; reg_operand = opr;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 cpsr reset", cpsr_q, 32'h0000_00D3);
    check("R1 spsr reset", spsr_q, 32'h0);
    check("R1 strobe reset", {31'h0, mode_chg}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(1'b0, V_SAV[i], V_MODE[i], V_INSTR[i], V_OPND[i]);
      check({V_TAG[i], " cpsr"}, cpsr_q, E_CPSR[i]);
      check({V_TAG[i], " spsr"}, spsr_q, E_SPSR[i]);
      check({V_TAG[i], " strobe"}, {31'h0, mode_chg}, {31'h0, E_CHG[i]});
      if (E_CHG[i]) check({V_TAG[i], " new_mode"}, {27'h0, new_mode}, {27'h0, E_NMODE[i]});
    end

    // R8: reads return the full registers and the destination field
    op_valid = 1'b1; op_read = 1'b1; op_saved = 1'b0; instr = 32'h0000_A000;
    #1;
    check("R8 read current", rd_data, 32'h0000_0010);
    check("R8 dest", {28'h0, rd_dest}, 32'hA);
    check("R8 valid", {31'h0, rd_valid}, 32'h1);
    op_saved = 1'b1; instr = 32'h0009_5000; reg_operand = 32'hFFFF_FFFF;
    #1;
    check("R8 read saved", rd_data, 32'hC000_0020);
    check("R8 dest saved", {28'h0, rd_dest}, 32'h5);
    @(negedge clk);
    op_valid = 1'b0;
    check("R8 read leaves spsr", spsr_q, 32'hC000_0020);
    check("R8 read leaves cpsr", cpsr_q, 32'h0000_0010);

    // R9: write fields with op_valid low
    op_read = 1'b0; op_saved = 1'b0; instr = 32'h0009_0000; reg_operand = 32'hF000_00DF;
    @(negedge clk);
    check("R9 idle cpsr", cpsr_q, 32'h0000_0010);
    check("R9 idle strobe", {31'h0, mode_chg}, 32'h0);

    // R4/R3 in same cycle: privileged write then read right after
    issue(1'b0, 1'b0, 5'h10, 32'h0009_0000, 32'h9000_00FF);
    check("R4 user dual write", cpsr_q, 32'h9000_0010);
    issue(1'b0, 1'b0, 5'h12, 32'h0009_0000, 32'h3000_003F);
    check("R4 state bit kept", cpsr_q, 32'h3000_001F);
    check("R5 strobe", {31'h0, mode_chg}, 32'h1);
    op_valid = 1'b1; op_read = 1'b1; op_saved = 1'b0; #1;
    check("R8 read after write", rd_data, 32'h3000_001F);
    @(negedge clk);
    op_valid = 1'b0;
    check("R5 strobe single pulse", {31'h0, mode_chg}, 32'h0);

    // R1: reset again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 cpsr re-reset", cpsr_q, 32'h0000_00D3);
    check("R1 spsr re-reset", spsr_q, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule